// File: doc/BRIEF.md
# Latched Event and Interrupt Status Unit

This unit gathers the condition and event signals of a serial bus controller into one 15-bit status word. Some of its bits mirror live conditions, such as FIFO fill flags or a busy line. Others catch single-cycle event pulses and hold them until software clears them. Examples of held events are a stop condition, a repeated start, lost arbitration, a NACK, or being addressed as a target. Each status bit can be enabled in a matching enable word. The unit drives one interrupt line while any enabled status bit is set.

Software reaches the unit through a small register port with four word addresses. Held events are cleared by writing ones to a dedicated clear address; bits written as zero there are left alone. A read-only priority field gives the index of the highest-numbered pending enabled bit. Error-type events therefore come ahead of data-flow events. A handler reads this field, services that cause and clears it. The bus engine that produces the conditions and pulses is outside this unit.

Top module: `evt_irq_unit`

## Requirements
- R1: Status bits 0–5, 9, 12, 13 and 14 are live bits: each reads, one cycle after sampling, the value its `cond_i` input had at the previous clock edge.
- R2: Status bits 6, 7, 8, 10 and 11 are held bits: a one-cycle pulse on the matching `evt_i` bit sets the status bit, and the bit stays set with no further pulse until it is cleared. A held bit with no pulse stays at zero.
- R3: A write to address 2 (clear) with a one at a held-bit position clears that bit at the write's clock edge. Held bits written as zero keep their value.
- R4: When a pulse and a clear hit the same held bit at the same edge, the bit ends up set.
- R5: Address 1 (enable) is read/write. Only bits 0–4, 6, 7, 8, 10, 11, 12 and 14 are stored; bits 5, 9, 13 and 15 read back as zero whatever was written.
- R6: `irq_o` is a registered output. After each clock edge it equals the OR over all bits of (status AND enable) as they stand after that edge, so it rises or falls in the cycle after the change that causes it.
- R7: A write of zero to the enable address masks every source, and `irq_o` is low from the edge that takes the write.
- R8: `prio_o`, also read at address 3 in the low 4 bits, gives the index of the highest-numbered bit set in (status AND enable). It reads 15 (all ones) when no such bit is set.
- R9: After a synchronous reset, status and enable are zero, `irq_o` is low and `prio_o` is 15.
- R10: Address 0 reads the status word zero-extended to 16 bits, and address 2 reads as zero.
- R11: Writes to the clear address do not affect live bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cond_i | input | 15 | Live condition levels from the bus engine |
| evt_i | input | 15 | Single-cycle event pulses (held-bit positions used) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address: 0 status, 1 enable, 2 clear, 3 priority |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| irq_o | output | 1 | Interrupt request |
| prio_o | output | 4 | Highest pending enabled index, 15 when none |

## Verification
The bench builds the unit with its default 15-bit status word and 16-bit register port. At that size every status bit can be walked one at a time through set, hold, partial clear, full clear and same-edge set-versus-clear. Every pair of sources can be raised together to check which index the priority field reports. A sweep of computed enable patterns over a fully set status word checks the masking of all unimplemented enable bits and the empty-priority code.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

    localparam int STAT_W = 15;
    localparam int DATA_W = 16;

    // positions that hold pulses until cleared (6,7,8,10,11)
    localparam logic [STAT_W-1:0] HELD_MASK = 15'h0DC0;
    // positions with an implemented enable
    localparam logic [STAT_W-1:0] ENA_MASK  = 15'h5DDF;

    typedef enum logic [1:0] {
        ADR_STAT = 2'd0,
        ADR_ENA  = 2'd1,
        ADR_CLR  = 2'd2,
        ADR_PRIO = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              ena_we;
        logic              clr_we;
        logic [STAT_W-1:0] data;
    } reg_cmd_t;

    function automatic int prio_width(input int w);
        return $clog2(w + 1);
    endfunction

endpackage

// File: rtl/evt_status_bank.sv
module evt_status_bank
    import evt_irq_pkg::*;
#(
    parameter int                W    = STAT_W,
    parameter logic [W-1:0]      HELD = HELD_MASK
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] cond_i,
    input  logic [W-1:0] evt_i,
    input  logic         clr_we,
    input  logic [W-1:0] clr_bits,
    output logic [W-1:0] stat_d,
    output logic [W-1:0] stat_q
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (HELD[i]) begin : g_held
            // set has priority over a same-edge clear
            assign stat_d[i] = evt_i[i] | (stat_q[i] & ~(clr_we & clr_bits[i]));

            // R4
            set_wins_chk: assert property (@(posedge clk) disable iff (rst)
                evt_i[i] |=> stat_q[i]);
            // R3
            clear_takes_chk: assert property (@(posedge clk) disable iff (rst)
                (clr_we && clr_bits[i] && !evt_i[i]) |=> !stat_q[i]);
            // R2
            held_stays_chk: assert property (@(posedge clk) disable iff (rst)
                (stat_q[i] && !(clr_we && clr_bits[i])) |=> stat_q[i]);
        end else begin : g_live
            assign stat_d[i] = cond_i[i];

            // R1
            live_high_chk: assert property (@(posedge clk) disable iff (rst)
                cond_i[i] |=> stat_q[i]);
            // R11
            live_low_chk: assert property (@(posedge clk) disable iff (rst)
                !cond_i[i] |=> !stat_q[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= stat_d;
    end

endmodule

// File: rtl/evt_enable_reg.sv
module evt_enable_reg
    import evt_irq_pkg::*;
#(
    parameter int           W    = STAT_W,
    parameter logic [W-1:0] IMPL = ENA_MASK
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] en_d,
    output logic [W-1:0] en_q
);

    assign en_d = we ? (wdata & IMPL) : en_q;

    always_ff @(posedge clk) begin
        if (rst) en_q <= '0;
        else     en_q <= en_d;
    end

    // R7
    mask_all_chk: assert property (@(posedge clk) disable iff (rst)
        (we && wdata == '0) |=> en_q == '0);

endmodule

// File: rtl/evt_prio_enc.sv
module evt_prio_enc #(
    parameter int W  = 15,
    parameter int PW = $clog2(W + 1)
) (
    input  logic [W-1:0]  pend,
    output logic [PW-1:0] idx
);

    always_comb begin
        idx = '1;
        for (int i = 0; i < W; i++) begin
            if (pend[i]) idx = PW'(i);
        end
    end

endmodule

// File: rtl/evt_irq_unit.sv
module evt_irq_unit
    import evt_irq_pkg::*;
#(
    parameter int W  = STAT_W,
    parameter int DW = DATA_W,
    localparam int PW = prio_width(W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [W-1:0]  cond_i,
    input  logic [W-1:0]  evt_i,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq_o,
    output logic [PW-1:0] prio_o
);

    localparam logic [PW-1:0] NONE = '1;

    reg_sel_e     sel;
    reg_cmd_t     cmd;
    logic [W-1:0] stat_d, stat_q, en_d, en_q, pend;
    logic         irq_q;

    assign sel        = reg_sel_e'(reg_addr);
    assign cmd.ena_we = reg_wr && (sel == ADR_ENA);
    assign cmd.clr_we = reg_wr && (sel == ADR_CLR);
    assign cmd.data   = reg_wdata[W-1:0];

    evt_status_bank #(.W(W), .HELD(HELD_MASK)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .cond_i   (cond_i),
        .evt_i    (evt_i),
        .clr_we   (cmd.clr_we),
        .clr_bits (cmd.data),
        .stat_d   (stat_d),
        .stat_q   (stat_q)
    );

    evt_enable_reg #(.W(W), .IMPL(ENA_MASK)) u_ena (
        .clk   (clk),
        .rst   (rst),
        .we    (cmd.ena_we),
        .wdata (cmd.data),
        .en_d  (en_d),
        .en_q  (en_q)
    );

    assign pend = stat_q & en_q;

    evt_prio_enc #(.W(W), .PW(PW)) u_prio (
        .pend (pend),
        .idx  (prio_o)
    );

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |(stat_d & en_d);
    end
    assign irq_o = irq_q;

    always_comb begin
        unique case (sel)
            ADR_STAT: reg_rdata = DW'(stat_q);
            ADR_ENA:  reg_rdata = DW'(en_q);
            ADR_CLR:  reg_rdata = '0;
            ADR_PRIO: reg_rdata = DW'(prio_o);
            default:  reg_rdata = '0;
        endcase
    end

    // R6
    irq_matches_prio_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o == (prio_o != NONE));
    // R8
    prio_top_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (pend != '0) |-> ((pend >> prio_o) == W'(1)));
    // R7
    irq_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && sel == ADR_ENA && reg_wdata == '0) |=> !irq_o);

endmodule

// File: tb/evt_irq_unit_tb.sv
`timescale 1ns/100ps
module evt_irq_unit_tb;

    localparam logic [14:0] LIVEM = 15'h723F;
    localparam logic [14:0] HELDM = 15'h0DC0;
    localparam logic [14:0] ENAM  = 15'h5DDF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [14:0] cond_i = '0;
    logic [14:0] evt_i = '0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq_o;
    logic [3:0]  prio_o;

    int total = 0;
    int bad = 0;

    logic [14:0] m_held = '0;
    logic [14:0] m_live = '0;
    logic [14:0] m_en = '0;

    always #2 clk = ~clk;

    evt_irq_unit u_dut (
        .clk(clk), .rst(rst), .cond_i(cond_i), .evt_i(evt_i),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_o(irq_o), .prio_o(prio_o)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] top_idx(input logic [14:0] p);
        logic [3:0] r = 4'hF;
        for (int i = 0; i < 15; i++) if (p[i]) r = 4'(i);
        return r;
    endfunction

    // compare all outputs against the model
    task automatic check_all(input string tag);
        logic [14:0] st;
        logic [14:0] pd;
        st = (m_live & LIVEM) | m_held;
        pd = st & m_en;
        chk({tag, " R6 irq"}, {15'd0, irq_o}, {15'd0, |pd});
        chk({tag, " R8 prio"}, {12'd0, prio_o}, {12'd0, top_idx(pd)});
        reg_addr = 2'd0; #0.2;
        chk({tag, " R10 status"}, reg_rdata, {1'b0, st});
        reg_addr = 2'd1; #0.2;
        chk({tag, " R5 enable"}, reg_rdata, {1'b0, m_en});
        reg_addr = 2'd3; #0.2;
        chk({tag, " R8 prio rd"}, reg_rdata, {12'd0, top_idx(pd)});
        reg_addr = 2'd2; #0.2;
        chk({tag, " R10 clr rd"}, reg_rdata, 16'd0);
    endtask

    // one clock: apply inputs, update model, check after the edge
    task automatic step(input logic [14:0] lv, input logic [14:0] ev,
                        input logic we, input logic [1:0] a,
                        input logic [15:0] d, input string tag);
        @(negedge clk);
        cond_i = lv; evt_i = ev; reg_wr = we; reg_addr = a; reg_wdata = d;
        if (we && a == 2'd2) m_held = m_held & ~d[14:0];
        m_held = m_held | (ev & HELDM);
        if (we && a == 2'd1) m_en = d[14:0] & ENAM;
        m_live = lv;
        @(posedge clk); #1;
        evt_i = '0; reg_wr = 1'b0;
        check_all(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        check_all("R9 reset");

        // R5: unimplemented enables drop
        step('0, '0, 1'b1, 2'd1, 16'hFFFF, "R5 en all");

        // per-bit walk
        for (int b = 0; b < 15; b++) begin
            logic [14:0] one;
            one = 15'(1) << b;
            if (HELDM[b]) begin
                step('0, one, 1'b0, 2'd0, '0, "R2 pulse");
                step('0, '0, 1'b0, 2'd0, '0, "R2 hold");
                step('0, '0, 1'b1, 2'd2, {1'b0, ~one}, "R3 other clr");
                step('0, '0, 1'b1, 2'd2, {1'b0, one}, "R3 clr");
                step('0, one, 1'b1, 2'd2, {1'b0, one}, "R4 set wins");
                step('0, '0, 1'b1, 2'd2, 16'hFFFF, "R3 clr all");
            end else begin
                step(one, '0, 1'b0, 2'd0, '0, "R1 live up");
                step(one, '0, 1'b1, 2'd2, 16'hFFFF, "R11 clr ignored");
                step('0, '0, 1'b0, 2'd0, '0, "R1 live down");
            end
        end

        // R8: every pair of sources together
        for (int i = 0; i < 15; i++) begin
            for (int j = i + 1; j < 15; j++) begin
                logic [14:0] pr;
                pr = (15'(1) << i) | (15'(1) << j);
                step(pr, pr, 1'b0, 2'd0, '0, "R8 pair");
                step('0, '0, 1'b1, 2'd2, 16'hFFFF, "R8 pair clr");
            end
        end

        // R5/R8: enable pattern sweep over a full status word
        for (int k = 0; k < 40; k++) begin
            logic [15:0] pat;
            pat = 16'(k * 16'h9E37) ^ 16'(k << 3);
            step(15'h7FFF, 15'h7FFF, 1'b1, 2'd1, pat, "R5 en sweep");
        end

        // R7: mask everything with causes pending
        step(15'h7FFF, 15'h7FFF, 1'b1, 2'd1, 16'hFFFF, "R6 all pending");
        step(15'h7FFF, '0, 1'b1, 2'd1, 16'h0000, "R7 mask all");
        chk("R7 irq low", {15'd0, irq_o}, 16'd0);
        // R6: re-enable one held cause, then clear it
        step(15'h0000, '0, 1'b1, 2'd1, 16'h0080, "R6 reenable");
        step(15'h0000, '0, 1'b1, 2'd2, 16'h0080, "R6 clear last");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule